// File: doc/BRIEF.md
# Peripheral Bus Bridge with Access-Error and Time-Out Monitor

This block sits between a CPU-side request port and a set of peripheral register targets. It takes one read or write request at a time and forwards it to the target side. It then holds the transaction open until the target acknowledges, and it returns the target's acknowledgement or read data as a single-cycle response.

While forwarding, the bridge watches for two faults. The first is an access error. An address that falls inside one of three monitored windows but has no implemented register behind it is refused at once with an error response, provided that checking is enabled. The second is a time-out. When time-out checking is enabled and a forwarded access sees no acknowledgement for a fixed number of cycles, the transaction is closed with an error response. Each fault leaves a sticky flag that software clears by writing 1. The bridge can also be put to sleep. While asleep it refuses new requests and checks nothing. Entering sleep while the neighbouring CPU or master-port domains are still active is itself flagged as an access error.

Top module: `pbus_err_bridge`

## Requirements
- R1: A request accepted when it is not refused is presented on the target side in the next cycle, with the same address, direction and write data. When the target acknowledges with `tgt_ack` at a clock edge, `resp_valid` is 1 for the cycle after that edge, with `resp_err` = 0. For a read, `resp_rdata` equals the target's `tgt_rdata`.
- R2: The monitored windows are 0x0000–0x03FF, 0x1400–0x17FF and 0x2000–0x23FF. A request whose address is in a window, with `reg_present` = 0 and `err_en` = 1, is refused. In the cycle after acceptance it gives `resp_valid` = 1, `resp_err` = 1 and status bit 0 (access error) = 1, and the target side stays idle.
- R3: A refused access sets status bit 1 if it was a write, or status bit 2 if it was a read, and never both for one access.
- R4: When `err_en` = 0, an in-window request with `reg_present` = 0 is forwarded as in R1, and no status bit is set.
- R5: An address outside all three windows is never refused, whatever the value of `reg_present`.
- R6: When `to_en` = 1 and a forwarded access has no acknowledgement, the response comes 512 clock edges after acceptance. It has `resp_err` = 1 and sets status bit 3 (time-out).
- R7: When `to_en` = 0, a forwarded access waits for its acknowledgement with no limit (tested beyond 512 cycles) and completes without error.
- R8: An acknowledgement arriving at the final edge of the time-out window takes priority: the response has no error, and status bit 3 stays 0.
- R9: Sleep is entered only in a cycle where `idle_req` and `idle_cmd` are both 1 and no transaction is open. While asleep, `req_ready` = 0, no response is produced and no status bit is set. `idle_cmd` alone has no effect.
- R10: If sleep is entered while `cpu_idle` or `mport_idle` is 0, status bit 0 is set.
- R11: `wake` while asleep returns the bridge to accepting requests in the next cycle.
- R12: Writing 1 to a bit of `stat_clr` clears that status bit. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU-side request present |
| req_ready | output | 1 | Bridge accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request I/O address |
| req_wdata | input | 16 | Write data |
| reg_present | input | 1 | Address decoder reports an implemented register at `req_addr` |
| resp_valid | output | 1 | Single-cycle response strobe |
| resp_err | output | 1 | Response carries an error |
| resp_rdata | output | 16 | Read data returned with the response |
| tgt_sel | output | 1 | Forwarded access open on the target side |
| tgt_write | output | 1 | Direction of the forwarded access |
| tgt_addr | output | 16 | Address of the forwarded access |
| tgt_wdata | output | 16 | Write data of the forwarded access |
| tgt_ack | input | 1 | Target acknowledgement |
| tgt_rdata | input | 16 | Target read data |
| err_en | input | 1 | Enable for access-error refusal |
| to_en | input | 1 | Enable for the no-response time-out |
| stat_clr | input | 4 | Write-1-to-clear strobes for the status bits |
| stat | output | 4 | Sticky status: bit0 access error, bit1 write, bit2 read, bit3 time-out |
| idle_req | input | 1 | Sleep request bit |
| idle_cmd | input | 1 | Sleep command strobe |
| cpu_idle | input | 1 | CPU domain is idle |
| mport_idle | input | 1 | Master-port domain is idle |
| wake | input | 1 | Leave sleep |
| sleeping | output | 1 | Bridge is asleep |

## Verification
A wrong window decode or a lost enable shows up in the cycle after acceptance. The bridge then either answers with an error where the bench expects the target to be selected, or the reverse. A time-out counter that is off by even one cycle moves the error response by one edge from edge 512. The same fault turns the acknowledgement in the final cycle of the window into a false time-out. A corrupted state register shows as a bridge that refuses requests when it should be awake, or that never answers. The status port exposes a wrong flag bit after every transaction, before the bench clears it.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_BUSY  = 2'd1,
      ST_SLEEP = 2'd2
   } pbe_state_e;

   localparam int STAT_W    = 4;
   localparam int STAT_ERR  = 0;
   localparam int STAT_WR   = 1;
   localparam int STAT_RD   = 2;
   localparam int STAT_TO   = 3;

endpackage

// File: rtl/pbe_win_check.sv
module pbe_win_check #(
   parameter int AW      = 16,
   parameter int NUM_WIN = 3,
   parameter int WIN_LG  = 10,
   parameter logic [NUM_WIN-1:0][AW-1:0] WIN_BASE = {16'h2000, 16'h1400, 16'h0000}
) (
   input  logic [AW-1:0]      addr,
   output logic [NUM_WIN-1:0] win_match,
   output logic               in_win
);

   if (AW <= WIN_LG) begin : g_bad_aw
      $error("pbe_win_check: AW must exceed WIN_LG");
   end
   if (NUM_WIN < 1) begin : g_bad_num
      $error("pbe_win_check: NUM_WIN must be at least 1");
   end

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      if (WIN_BASE[g][WIN_LG-1:0] != '0) begin : g_align
         $error("pbe_win_check: window base not aligned to window size");
      end
      assign win_match[g] = (addr[AW-1:WIN_LG] == WIN_BASE[g][AW-1:WIN_LG]);
   end

   assign in_win = |win_match;

endmodule

// File: rtl/pbe_timer.sv
module pbe_timer #(
   parameter int TO_CYCLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic en,
   output logic fire
);

   localparam int CW = (TO_CYCLES > 1) ? $clog2(TO_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(TO_CYCLES - 1);

   if (TO_CYCLES < 2) begin : g_bad_to
      $error("pbe_timer: TO_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (start)  cnt <= '0;
      else if (run)    cnt <= cnt + 1'b1;
   end

   assign fire = run && en && (cnt == LAST);

   // R6: the counter starts from zero on every new transaction
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == '0));

endmodule

// File: rtl/pbe_status.sv
module pbe_status #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] flag
);

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flag[b] <= 1'b0;
         else if (set[b])  flag[b] <= 1'b1;
         else if (clr[b])  flag[b] <= 1'b0;
      end

      // R12: write-1-to-clear, set wins
      p_w1c_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[b] && !set[b]) |=> !flag[b]);
      p_setwin_r12: assert property (@(posedge clk) disable iff (!rst_n)
         set[b] |=> flag[b]);
   end

endmodule

// File: rtl/pbus_err_bridge.sv
module pbus_err_bridge #(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int NUM_WIN   = 3,
   parameter int WIN_LG    = 10,
   parameter logic [NUM_WIN-1:0][AW-1:0] WIN_BASE = {16'h2000, 16'h1400, 16'h0000},
   parameter int TO_CYCLES = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          reg_present,
   output logic          resp_valid,
   output logic          resp_err,
   output logic [DW-1:0] resp_rdata,
   output logic          tgt_sel,
   output logic          tgt_write,
   output logic [AW-1:0] tgt_addr,
   output logic [DW-1:0] tgt_wdata,
   input  logic          tgt_ack,
   input  logic [DW-1:0] tgt_rdata,
   input  logic          err_en,
   input  logic          to_en,
   input  logic [3:0]    stat_clr,
   output logic [3:0]    stat,
   input  logic          idle_req,
   input  logic          idle_cmd,
   input  logic          cpu_idle,
   input  logic          mport_idle,
   input  logic          wake,
   output logic          sleeping
);
   import pbe_pkg::*;

   if (DW < 1) begin : g_bad_dw
      $error("pbus_err_bridge: DW must be positive");
   end

   pbe_state_e         state;
   logic [NUM_WIN-1:0] win_match;
   logic               in_win;
   logic               go_sleep;
   logic               accept;
   logic               refuse;
   logic               to_fire;
   logic [STAT_W-1:0]  stat_set;

   pbe_win_check #(
      .AW(AW), .NUM_WIN(NUM_WIN), .WIN_LG(WIN_LG), .WIN_BASE(WIN_BASE)
   ) u_win (
      .addr(req_addr), .win_match(win_match), .in_win(in_win)
   );

   assign go_sleep  = (state == ST_READY) && idle_req && idle_cmd;
   assign req_ready = (state == ST_READY) && !go_sleep;
   assign accept    = req_valid && req_ready;
   assign refuse    = in_win && !reg_present && err_en;
   assign tgt_sel   = (state == ST_BUSY);
   assign sleeping  = (state == ST_SLEEP);

   pbe_timer #(.TO_CYCLES(TO_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start(accept && !refuse),
      .run(tgt_sel && !tgt_ack),
      .en(to_en),
      .fire(to_fire)
   );

   always_comb begin
      stat_set           = '0;
      stat_set[STAT_ERR] = (accept && refuse) ||
                           (go_sleep && !(cpu_idle && mport_idle));
      stat_set[STAT_WR]  = accept && refuse && req_write;
      stat_set[STAT_RD]  = accept && refuse && !req_write;
      stat_set[STAT_TO]  = tgt_sel && !tgt_ack && to_fire;
   end

   pbe_status #(.W(STAT_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .set(stat_set), .clr(stat_clr), .flag(stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_READY;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
         tgt_write  <= 1'b0;
         tgt_addr   <= '0;
         tgt_wdata  <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state)
            ST_READY: begin
               if (go_sleep) begin
                  state <= ST_SLEEP;
               end else if (accept) begin
                  if (refuse) begin
                     resp_valid <= 1'b1;
                     resp_err   <= 1'b1;
                     resp_rdata <= '0;
                  end else begin
                     state     <= ST_BUSY;
                     tgt_write <= req_write;
                     tgt_addr  <= req_addr;
                     tgt_wdata <= req_wdata;
                  end
               end
            end
            ST_BUSY: begin
               if (tgt_ack) begin
                  state      <= ST_READY;
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b0;
                  resp_rdata <= tgt_rdata;
               end else if (to_fire) begin
                  state      <= ST_READY;
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b1;
                  resp_rdata <= '0;
               end
            end
            ST_SLEEP: begin
               if (wake) state <= ST_READY;
            end
            default: state <= ST_READY;
         endcase
      end
   end

   // R1: an accepted, unrefused request opens the target side next cycle
   p_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !refuse) |=> (tgt_sel && tgt_addr == $past(req_addr)));

   // R2: a refused access answers with an error at once
   p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && refuse) |=> (resp_valid && resp_err && stat[STAT_ERR] && !tgt_sel));

   // R3: a single refusal never marks both directions
   p_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[STAT_WR]) |-> !$rose(stat[STAT_RD]));

   // R5: outside the windows nothing is refused
   p_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !in_win) |=> tgt_sel);

   // R6: the time-out closes the transaction with an error
   p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel && !tgt_ack && to_fire) |=> (resp_valid && resp_err && stat[STAT_TO]));

   // R8: an acknowledgement never produces an error response
   p_ack_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel && tgt_ack) |=> (resp_valid && !resp_err));

   // R9: asleep means no acceptance and no response
   p_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sleeping |-> (!req_ready && !resp_valid));

   // R10: sleeping with active neighbours raises the access error
   p_idle_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (go_sleep && !(cpu_idle && mport_idle)) |=> (sleeping && stat[STAT_ERR]));

   // R2: the monitored windows do not overlap
   p_win_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot0(win_match));

endmodule

// File: tb/test_pbus_err_bridge.sv
module test_pbus_err_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, reg_present = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic        req_ready, resp_valid, resp_err;
   logic [15:0] resp_rdata;
   logic        tgt_sel, tgt_write;
   logic [15:0] tgt_addr, tgt_wdata;
   logic        tgt_ack = 1'b0;
   logic [15:0] tgt_rdata = '0;
   logic        err_en = 1'b1, to_en = 1'b1;
   logic [3:0]  stat_clr = '0;
   logic [3:0]  stat;
   logic        idle_req = 1'b0, idle_cmd = 1'b0, cpu_idle = 1'b1, mport_idle = 1'b1, wake = 1'b0;
   logic        sleeping;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pbus_err_bridge i_pbus_err_bridge (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .reg_present(reg_present),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .tgt_sel(tgt_sel), .tgt_write(tgt_write), .tgt_addr(tgt_addr),
      .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata),
      .err_en(err_en), .to_en(to_en), .stat_clr(stat_clr), .stat(stat),
      .idle_req(idle_req), .idle_cmd(idle_cmd), .cpu_idle(cpu_idle),
      .mport_idle(mport_idle), .wake(wake), .sleeping(sleeping)
   );

   function automatic bit in_window(logic [15:0] a);
      return (a < 16'h0400) || (a >= 16'h1400 && a < 16'h1800) ||
             (a >= 16'h2000 && a < 16'h2400);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_stat();
      stat_clr = 4'hF;
      @(posedge clk); @(negedge clk);
      stat_clr = 4'h0;
   endtask

   // dly < 0 means the target never answers
   task automatic access(bit wr, logic [15:0] a, bit pres, int dly, bit een, bit ten, string req);
      bit          bad;
      int          n;
      int          exp_n;
      logic [15:0] wd, rd;
      wd = 16'($urandom);
      rd = 16'($urandom);
      bad = in_window(a) && !pres && een;
      err_en = een; to_en = ten;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; reg_present = pres;
      chk(req_ready == 1'b1, req, int'(req_ready), 1);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      if (bad) begin
         chk(resp_valid && resp_err && !tgt_sel, req, {resp_valid, resp_err, tgt_sel}, 3'b110);
         chk(stat == (wr ? 4'b0011 : 4'b0101), {req, " R3"}, int'(stat), wr ? 3 : 5);
      end else begin
         chk(tgt_sel && tgt_addr == a && tgt_write == wr, {req, " R1"}, int'(tgt_addr), int'(a));
         if (wr) chk(tgt_wdata == wd, {req, " R1"}, int'(tgt_wdata), int'(wd));
         n = 0;
         while (1) begin
            if (n == dly) begin tgt_ack = 1'b1; tgt_rdata = rd; end
            @(posedge clk); @(negedge clk);
            tgt_ack = 1'b0;
            n++;
            if (resp_valid || n > 700) break;
         end
         if (dly >= 0 && (dly < 512 || !ten)) begin
            exp_n = dly + 1;
            chk(n == exp_n && !resp_err, req, n, exp_n);
            if (!wr) chk(resp_rdata == rd, {req, " R1"}, int'(resp_rdata), int'(rd));
            chk(stat == 4'b0000, req, int'(stat), 0);
         end else begin
            chk(n == 512 && resp_err, {req, " R6"}, n, 512);
            chk(stat == 4'b1000, {req, " R6"}, int'(stat), 8);
         end
      end
      clear_stat();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // reset state
      chk(!resp_valid && !tgt_sel && !sleeping && stat == 0, "reset",
          {resp_valid, tgt_sel, sleeping}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "reset R1", int'(req_ready), 1);

      // directed
      access(1'b0, 16'h1234, 1'b1, 3, 1'b1, 1'b1, "R1 read");
      access(1'b1, 16'h0100, 1'b1, 0, 1'b1, 1'b1, "R1 write");
      access(1'b1, 16'h03FF, 1'b0, 2, 1'b1, 1'b1, "R2 win0 edge");
      access(1'b0, 16'h1400, 1'b0, 2, 1'b1, 1'b1, "R2 win1 edge");
      access(1'b0, 16'h23FF, 1'b0, 2, 1'b1, 1'b1, "R2 win2 edge");
      access(1'b0, 16'h0400, 1'b0, 1, 1'b1, 1'b1, "R5 above win0");
      access(1'b1, 16'h13FF, 1'b0, 1, 1'b1, 1'b1, "R5 below win1");
      access(1'b0, 16'h2400, 1'b0, 1, 1'b1, 1'b1, "R5 above win2");
      access(1'b0, 16'h0200, 1'b0, 4, 1'b0, 1'b1, "R4 check off");
      access(1'b0, 16'h5000, 1'b1, -1, 1'b1, 1'b1, "R6 timeout");
      access(1'b0, 16'h5000, 1'b1, 511, 1'b1, 1'b1, "R8 late ack");
      access(1'b1, 16'h5000, 1'b1, 600, 1'b1, 1'b0, "R7 no limit");

      // R12: clear in the same cycle as a set keeps the flag
      err_en = 1'b1;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h2010; reg_present = 1'b0;
      stat_clr = 4'hF;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; stat_clr = 4'h0;
      chk(stat == 4'b0101, "R12 set wins", int'(stat), 5);
      stat_clr = 4'b0001;
      @(posedge clk); @(negedge clk);
      stat_clr = 4'h0;
      chk(stat == 4'b0100, "R12 clear one bit", int'(stat), 4);
      clear_stat();

      // R9: command without request bit does nothing
      idle_cmd = 1'b1;
      @(posedge clk); @(negedge clk);
      idle_cmd = 1'b0;
      chk(!sleeping && req_ready, "R9 cmd alone", int'(sleeping), 0);
      // R9: enter sleep with quiet neighbours
      idle_req = 1'b1; idle_cmd = 1'b1;
      @(posedge clk); @(negedge clk);
      idle_cmd = 1'b0; idle_req = 1'b0;
      chk(sleeping && stat == 0, "R9 enter", {sleeping, stat}, 5'b10000);
      req_valid = 1'b1; req_addr = 16'h0010; reg_present = 1'b0;
      for (int i = 0; i < 5; i++) begin
         chk(!req_ready, "R9 refuse", int'(req_ready), 0);
         @(posedge clk); @(negedge clk);
         chk(!resp_valid && !tgt_sel && stat == 0, "R9 silent",
             {resp_valid, tgt_sel, stat}, 0);
      end
      req_valid = 1'b0;
      wake = 1'b1;
      @(posedge clk); @(negedge clk);
      wake = 1'b0;
      chk(!sleeping && req_ready, "R11 wake", int'(req_ready), 1);
      access(1'b0, 16'h3000, 1'b1, 1, 1'b1, 1'b1, "R11 after wake");
      // R10: neighbours active
      cpu_idle = 1'b0; idle_req = 1'b1; idle_cmd = 1'b1;
      @(posedge clk); @(negedge clk);
      idle_req = 1'b0; idle_cmd = 1'b0; cpu_idle = 1'b1;
      chk(sleeping && stat == 4'b0001, "R10 busy cpu", int'(stat), 1);
      wake = 1'b1;
      @(posedge clk); @(negedge clk);
      wake = 1'b0;
      clear_stat();
      mport_idle = 1'b0; idle_req = 1'b1; idle_cmd = 1'b1;
      @(posedge clk); @(negedge clk);
      idle_req = 1'b0; idle_cmd = 1'b0; mport_idle = 1'b1;
      chk(sleeping && stat == 4'b0001, "R10 busy mport", int'(stat), 1);
      wake = 1'b1;
      @(posedge clk); @(negedge clk);
      wake = 1'b0;
      clear_stat();

      // random mix
      for (int t = 0; t < 120; t++) begin
         logic [15:0] a;
         int          pick;
         int          d;
         pick = int'($urandom % 4);
         case (pick)
            0: a = 16'h0000 + 16'($urandom % 1024);
            1: a = 16'h1400 + 16'($urandom % 1024);
            2: a = 16'h2000 + 16'($urandom % 1024);
            default: a = 16'($urandom);
         endcase
         d = ($urandom % 16 == 0) ? -1 : int'($urandom % 12);
         access(1'($urandom), a, 1'($urandom), d, ($urandom % 4 != 0),
                1'b1, "R2 R4 R5 random");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule